// File: doc/BRIEF.md
# Instruction Serialization Barrier Controller

This block sits in the instruction fetch path, between the fetch buffer and the rename/dispatch stage. It sees one instruction per cycle with a small set of per-instruction serialization flags, and decides whether that instruction may pass, must wait until the machine has drained, or forces the instruction after it to wait. Instruction decode is done elsewhere. This block only acts on flags that are already decoded.

An instruction that has to serialize before it runs is a control-register access, or an instruction whose serialize-before flag is set and not yet handled. The controller does not forward it. It keeps the instruction in a holding register and raises a fetch block. The held instruction is replayed only after the downstream reorder buffer and the instruction queue have both reported empty. On replay its serialize-before flag is cleared. An instruction that has to serialize after it runs is a store-conditional or a serialize-after instruction. It passes with its handled flag set, and a pending flag then turns the next accepted instruction into a serialize-before instruction. A squash discards the held instruction and any pending state. Three event counters record serializing barriers, temporary barriers and stall cycles.

Top module: `sb_barrier_top`

## Requirements
- R1: An accepted instruction whose flags have ctrlReg (bit 3) set, or serBefore (bit 0) set, and handled (bit 5) clear is not forwarded. fetchBlock is high from the next cycle until the barrier is replayed.
- R2: An accepted instruction with storeCond (bit 2) or serAfter (bit 1) set and handled clear, and that is not a barrier under R1, appears on the output one cycle later with handled set. fetchBlock is high for exactly that one cycle.
- R3: After an R2 instruction, the next accepted instruction is treated as having serBefore set. If its handled bit is clear it becomes a barrier. Otherwise it is forwarded with serBefore set. The pending state is then cleared.
- R4: serializingCount increments once for each non-temporary barrier (tempSer, bit 4, clear) and once for each R2 instruction. tempSerializingCount increments once for each barrier with tempSer set. A non-temporary barrier is replayed with handled set, and a temporary one is replayed with handled unchanged.
- R5: The barrier leaves the blocked state only at a clock edge where it is blocked and robEmpty and iqEmpty are both high. It is replayed on the output after the following edge.
- R6: On replay, outValid and barrierRelease are high together, outTag is the held tag, serBefore is clear and the other flags are retained. fetchBlock is low in the same cycle.
- R7: stallCount increments on every clock edge at which the controller is in the blocked state.
- R8: squash drops the held barrier, the pending state and that cycle's input. The next cycle shows outValid low and fetchBlock low, and the counters keep their values.
- R9: An accepted instruction with no serialization need is forwarded one cycle later with an unchanged tag and unchanged flags. An instruction presented while fetchBlock is high is ignored.
- R10: After reset, outValid, barrierRelease and fetchBlock are low and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction present this cycle |
| inFlags | input | 6 | {handled, tempSer, ctrlReg, storeCond, serAfter, serBefore} |
| inTag | input | TAG_W | Opaque instruction tag |
| robEmpty | input | 1 | Reorder buffer is empty |
| iqEmpty | input | 1 | Instruction queue is empty |
| squash | input | 1 | Flush fetch-path serialization state |
| fetchBlock | output | 1 | Upstream must not present instructions |
| outValid | output | 1 | Instruction forwarded this cycle |
| outFlags | output | 6 | Flags of the forwarded instruction |
| outTag | output | TAG_W | Tag of the forwarded instruction |
| barrierRelease | output | 1 | Forwarded instruction is the replayed barrier |
| serializingCount | output | CNT_W | Non-temporary barriers plus serialize-after events |
| tempSerializingCount | output | CNT_W | Temporary barriers |
| stallCount | output | CNT_W | Cycles spent blocked on a barrier |

## Verification
A wrong blocked/complete state shows at the ports within one cycle. fetchBlock would stay high or drop early, and stallCount would drift on every blocked edge. A lost or stale pending serialize-after bit shows on the next accepted instruction, which is then either forwarded with the wrong serBefore bit or captured when it should have passed. A corrupted holding register is visible only at replay, two edges after the drained condition, through outTag and the handled and serBefore bits.

// File: rtl/sb_barrier_pkg.sv
package sb_barrier_pkg;

  localparam int FLAG_W = 6;

  typedef struct packed {
    logic handled;
    logic tempSer;
    logic ctrlReg;
    logic storeCond;
    logic serAfter;
    logic serBefore;
  } instFlags_t;

  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_BLOCKED  = 2'd1,
    ST_COMPLETE = 2'd2
  } fetchState_t;

  localparam int NUM_CNT = 3;
  localparam int CNT_SER  = 0;
  localparam int CNT_TEMP = 1;
  localparam int CNT_STALL = 2;

  typedef struct packed {
    logic passInst;
    logic captureBarrier;
    logic emitBarrier;
    logic clearHeld;
    logic forceSerBefore;
    logic markHandled;
    logic [NUM_CNT-1:0] incCnt;
  } ctrlStrobe_t;

endpackage

// File: rtl/sb_barrier_ctrl.sv
module sb_barrier_ctrl
  import sb_barrier_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  instFlags_t  inFlags,
  input  logic        robEmpty,
  input  logic        iqEmpty,
  input  logic        squash,
  output ctrlStrobe_t strobe,
  output logic        fetchBlock,
  output fetchState_t ctrlState
);

  fetchState_t stateQ, stateD;
  logic pendingAfterQ, pendingAfterD;
  logic stopQ, stopD;

  logic accept;
  logic effSerBefore;
  logic needBarrier;
  logic needAfter;
  logic drained;

  assign drained      = robEmpty & iqEmpty;
  assign accept       = (stateQ == ST_RUN) & ~stopQ & inValid & ~squash;
  assign effSerBefore = inFlags.serBefore | pendingAfterQ;
  assign needBarrier  = (inFlags.ctrlReg | effSerBefore) & ~inFlags.handled;
  assign needAfter    = (inFlags.storeCond | inFlags.serAfter) & ~inFlags.handled;

  always_comb begin
    strobe = '0;
    strobe.passInst       = accept & ~needBarrier;
    strobe.captureBarrier = accept & needBarrier;
    strobe.emitBarrier    = (stateQ == ST_COMPLETE) & ~squash;
    strobe.clearHeld      = squash;
    strobe.forceSerBefore = pendingAfterQ;
    strobe.markHandled    = needBarrier ? ~inFlags.tempSer : needAfter;
    strobe.incCnt[CNT_SER]   = accept & ((needBarrier & ~inFlags.tempSer) |
                                         (~needBarrier & needAfter));
    strobe.incCnt[CNT_TEMP]  = accept & needBarrier & inFlags.tempSer;
    strobe.incCnt[CNT_STALL] = (stateQ == ST_BLOCKED);
  end

  always_comb begin
    stateD        = stateQ;
    pendingAfterD = pendingAfterQ;
    stopD         = 1'b0;
    if (squash) begin
      stateD        = ST_RUN;
      pendingAfterD = 1'b0;
    end else begin
      unique case (stateQ)
        ST_RUN: begin
          if (accept) begin
            pendingAfterD = ~needBarrier & needAfter;
            stopD         = ~needBarrier & needAfter;
            if (needBarrier) stateD = ST_BLOCKED;
          end
        end
        ST_BLOCKED: begin
          if (drained) stateD = ST_COMPLETE;
        end
        ST_COMPLETE: begin
          stateD = ST_RUN;
        end
        default: stateD = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ        <= ST_RUN;
      pendingAfterQ <= 1'b0;
      stopQ         <= 1'b0;
    end else begin
      stateQ        <= stateD;
      pendingAfterQ <= pendingAfterD;
      stopQ         <= stopD;
    end
  end

  assign fetchBlock = (stateQ != ST_RUN) | stopQ;
  assign ctrlState  = stateQ;

endmodule

// File: rtl/sb_barrier_dp.sv
module sb_barrier_dp
  import sb_barrier_pkg::*;
#(
  parameter int TAG_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobe_t      strobe,
  input  instFlags_t       inFlags,
  input  logic [TAG_W-1:0] inTag,
  output logic             outValid,
  output instFlags_t       outFlags,
  output logic [TAG_W-1:0] outTag,
  output logic             barrierRelease,
  output logic [CNT_W-1:0] cntValue [NUM_CNT]
);

  logic [TAG_W-1:0] heldTag;
  instFlags_t       heldFlags;
  instFlags_t       passFlags;
  instFlags_t       captFlags;
  instFlags_t       replayFlags;

  always_comb begin
    passFlags           = inFlags;
    passFlags.serBefore = inFlags.serBefore | strobe.forceSerBefore;
    passFlags.handled   = inFlags.handled | strobe.markHandled;

    captFlags           = inFlags;
    captFlags.serBefore = inFlags.serBefore | strobe.forceSerBefore;
    captFlags.handled   = inFlags.handled | strobe.markHandled;

    replayFlags           = heldFlags;
    replayFlags.serBefore = 1'b0;
  end

  // Holding register for the barrier instruction
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      heldTag   <= '0;
      heldFlags <= '0;
    end else if (strobe.clearHeld) begin
      heldTag   <= '0;
      heldFlags <= '0;
    end else if (strobe.captureBarrier) begin
      heldTag   <= inTag;
      heldFlags <= captFlags;
    end
  end

  // Output stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid       <= 1'b0;
      outFlags       <= '0;
      outTag         <= '0;
      barrierRelease <= 1'b0;
    end else begin
      outValid       <= strobe.passInst | strobe.emitBarrier;
      barrierRelease <= strobe.emitBarrier;
      if (strobe.emitBarrier) begin
        outTag   <= heldTag;
        outFlags <= replayFlags;
      end else if (strobe.passInst) begin
        outTag   <= inTag;
        outFlags <= passFlags;
      end
    end
  end

  // Event counters
  generate
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
      logic [CNT_W-1:0] cntQ;
      always_ff @(posedge clk) begin
        if (!rst_n)               cntQ <= '0;
        else if (strobe.incCnt[g]) cntQ <= cntQ + 1'b1;
      end
      assign cntValue[g] = cntQ;
    end
  endgenerate

endmodule

// File: rtl/sb_barrier_top.sv
module sb_barrier_top
  import sb_barrier_pkg::*;
#(
  parameter int TAG_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic [5:0]       inFlags,
  input  logic [TAG_W-1:0] inTag,
  input  logic             robEmpty,
  input  logic             iqEmpty,
  input  logic             squash,
  output logic             fetchBlock,
  output logic             outValid,
  output logic [5:0]       outFlags,
  output logic [TAG_W-1:0] outTag,
  output logic             barrierRelease,
  output logic [CNT_W-1:0] serializingCount,
  output logic [CNT_W-1:0] tempSerializingCount,
  output logic [CNT_W-1:0] stallCount
);

  ctrlStrobe_t      strobe;
  fetchState_t      ctrlState;
  instFlags_t       inFlagsS;
  instFlags_t       outFlagsS;
  logic [CNT_W-1:0] cntValue [NUM_CNT];

  assign inFlagsS = instFlags_t'(inFlags);

  sb_barrier_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .inValid    (inValid),
    .inFlags    (inFlagsS),
    .robEmpty   (robEmpty),
    .iqEmpty    (iqEmpty),
    .squash     (squash),
    .strobe     (strobe),
    .fetchBlock (fetchBlock),
    .ctrlState  (ctrlState)
  );

  sb_barrier_dp #(
    .TAG_W (TAG_W),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .strobe         (strobe),
    .inFlags        (inFlagsS),
    .inTag          (inTag),
    .outValid       (outValid),
    .outFlags       (outFlagsS),
    .outTag         (outTag),
    .barrierRelease (barrierRelease),
    .cntValue       (cntValue)
  );

  assign outFlags             = outFlagsS;
  assign serializingCount     = cntValue[CNT_SER];
  assign tempSerializingCount = cntValue[CNT_TEMP];
  assign stallCount           = cntValue[CNT_STALL];

endmodule

// File: rtl/sb_barrier_chk.sv
module sb_barrier_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inValid,
  input logic [5:0]       inFlags,
  input logic             robEmpty,
  input logic             iqEmpty,
  input logic             squash,
  input logic             fetchBlock,
  input logic             outValid,
  input logic [5:0]       outFlags,
  input logic             barrierRelease,
  input logic [CNT_W-1:0] serializingCount,
  input logic [CNT_W-1:0] stallCount,
  input logic [1:0]       ctrlState
);

  p_barrier_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !fetchBlock && !squash && inFlags[3] && !inFlags[5])
      |=> (fetchBlock && !outValid));

  p_after_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !fetchBlock && !squash && (inFlags[2] || inFlags[1]) && !inFlags[5]
     && !inFlags[3] && !inFlags[0])
      |=> ((outValid && outFlags[5] && fetchBlock) || (!outValid && fetchBlock)));

  p_ser_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(serializingCount) |-> (serializingCount == $past(serializingCount) + 1'b1));

  p_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    barrierRelease |-> $past(robEmpty && iqEmpty, 2));

  p_release_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    barrierRelease |-> (outValid && !outFlags[0] && !fetchBlock));

  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlState == 2'd1) |=> (stallCount == $past(stallCount) + 1'b1));

  p_squash_r8: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> (!outValid && !fetchBlock));

endmodule

bind sb_barrier_top sb_barrier_chk #(.CNT_W(CNT_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .inValid          (inValid),
  .inFlags          (inFlags),
  .robEmpty         (robEmpty),
  .iqEmpty          (iqEmpty),
  .squash           (squash),
  .fetchBlock       (fetchBlock),
  .outValid         (outValid),
  .outFlags         (outFlags),
  .barrierRelease   (barrierRelease),
  .serializingCount (serializingCount),
  .stallCount       (stallCount),
  .ctrlState        (ctrlState)
);

// File: tb/sb_barrier_top_tb.sv
`timescale 1ns/1ps
module sb_barrier_top_tb;

  localparam int TAG_W = 16;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             inValid;
  logic [5:0]       inFlags;
  logic [TAG_W-1:0] inTag;
  logic             robEmpty;
  logic             iqEmpty;
  logic             squash;
  logic             fetchBlock;
  logic             outValid;
  logic [5:0]       outFlags;
  logic [TAG_W-1:0] outTag;
  logic             barrierRelease;
  logic [CNT_W-1:0] serializingCount;
  logic [CNT_W-1:0] tempSerializingCount;
  logic [CNT_W-1:0] stallCount;

  always #2.5 clk = ~clk;

  sb_barrier_top #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inFlags(inFlags), .inTag(inTag),
    .robEmpty(robEmpty), .iqEmpty(iqEmpty), .squash(squash),
    .fetchBlock(fetchBlock), .outValid(outValid), .outFlags(outFlags), .outTag(outTag),
    .barrierRelease(barrierRelease), .serializingCount(serializingCount),
    .tempSerializingCount(tempSerializingCount), .stallCount(stallCount)
  );

  int nCompared = 0;
  int nMismatched = 0;
  bit summaryDone = 0;

  // Reference state derived from the requirements
  int               mSt;      // 0 run, 1 blocked, 2 complete
  bit               mPend, mStop;
  logic [TAG_W-1:0] mHeldTag;
  logic [5:0]       mHeldFlags;
  bit               mOutV, mRel;
  logic [TAG_W-1:0] mOutTag;
  logic [5:0]       mOutFlags;
  logic [CNT_W-1:0] mSer, mTemp, mStall;

  function automatic bit expBlock();
    return (mSt != 0) || mStop;
  endfunction

  task automatic modelReset();
    mSt = 0; mPend = 0; mStop = 0; mHeldTag = '0; mHeldFlags = '0;
    mOutV = 0; mRel = 0; mOutTag = '0; mOutFlags = '0;
    mSer = '0; mTemp = '0; mStall = '0;
  endtask

  task automatic modelStep();
    bit acc, effSB, needB, needA;
    logic [5:0] f;
    mOutV = 0; mRel = 0;
    if (mSt == 1) mStall = mStall + 1'b1;                 // R7
    if (squash) begin                                      // R8
      mSt = 0; mPend = 0; mStop = 0;
      mHeldTag = '0; mHeldFlags = '0;
    end else if (mSt == 0) begin
      acc = inValid && !mStop;
      mStop = 0;
      if (acc) begin
        effSB = inFlags[0] || mPend;
        needB = (inFlags[3] || effSB) && !inFlags[5];
        needA = (inFlags[2] || inFlags[1]) && !inFlags[5];
        f = inFlags;
        f[0] = effSB;
        if (needB) begin                                   // R1
          if (!inFlags[4]) begin f[5] = 1'b1; mSer = mSer + 1'b1; end
          else mTemp = mTemp + 1'b1;
          mHeldTag = inTag; mHeldFlags = f;
          mSt = 1; mPend = 0;
        end else begin                                     // R9 / R2 / R3
          if (needA) begin f[5] = 1'b1; mSer = mSer + 1'b1; end
          mPend = needA; mStop = needA;
          mOutV = 1; mOutTag = inTag; mOutFlags = f;
        end
      end
    end else if (mSt == 1) begin
      if (robEmpty && iqEmpty) mSt = 2;                    // R5
    end else begin
      mOutV = 1; mRel = 1; mOutTag = mHeldTag;             // R6
      mOutFlags = mHeldFlags; mOutFlags[0] = 1'b0;
      mSt = 0; mStop = 0;
    end
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nCompared++;
    if (act !== exp) begin
      nMismatched++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input string req);
    modelStep();
    @(posedge clk);
    #1;
    chk(req, "outValid", 32'(outValid), 32'(mOutV));
    if (mOutV) begin
      chk(req, "outTag", 32'(outTag), 32'(mOutTag));
      chk(req, "outFlags", 32'(outFlags), 32'(mOutFlags));
    end
    chk(req, "barrierRelease", 32'(barrierRelease), 32'(mRel));
    chk(req, "fetchBlock", 32'(fetchBlock), 32'(expBlock()));
    chk(req, "serializingCount", 32'(serializingCount), 32'(mSer));
    chk(req, "tempSerializingCount", 32'(tempSerializingCount), 32'(mTemp));
    chk(req, "stallCount", 32'(stallCount), 32'(mStall));
  endtask

  task automatic drive(input bit v, input logic [5:0] f, input logic [TAG_W-1:0] t,
                       input bit rob, input bit iq, input bit sq);
    inValid = v; inFlags = f; inTag = t; robEmpty = rob; iqEmpty = iq; squash = sq;
  endtask

  task automatic summary();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nMismatched++;
    nCompared++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    drive(0, 6'h00, '0, 1, 1, 0);
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;

    // R10: reset state
    chk("R10", "outValid", 32'(outValid), 0);
    chk("R10", "fetchBlock", 32'(fetchBlock), 0);
    chk("R10", "barrierRelease", 32'(barrierRelease), 0);
    chk("R10", "counters", 32'(serializingCount | tempSerializingCount | stallCount), 0);

    // R9: plain pass-through
    drive(1, 6'h00, 16'h0011, 1, 1, 0); step("R9");
    chk("R9", "plain tag", 32'(outTag), 32'h11);

    // R1: control-register barrier, not yet drained
    drive(1, 6'h08, 16'h0022, 0, 0, 0); step("R1");
    chk("R1", "blocked", 32'(fetchBlock), 1);
    // R9: inputs during block ignored
    drive(1, 6'h00, 16'h0033, 0, 1, 0); step("R9");
    drive(1, 6'h00, 16'h0034, 0, 1, 0); step("R9");
    // R5: only one side drained
    drive(0, 6'h00, 16'h0000, 1, 0, 0); step("R5");
    drive(0, 6'h00, 16'h0000, 1, 1, 0); step("R5");
    chk("R5", "no early replay", 32'(outValid), 0);
    drive(0, 6'h00, 16'h0000, 1, 1, 0); step("R6");
    chk("R6", "replay tag", 32'(outTag), 32'h22);
    chk("R6", "replay flags", 32'(outFlags), 32'h28);
    chk("R6", "release", 32'(barrierRelease), 1);
    chk("R7", "stall cycles", 32'(stallCount), 4);
    chk("R4", "ser count", 32'(serializingCount), 1);

    // R2: serialize-after passes, one-cycle stop
    drive(1, 6'h02, 16'h0044, 1, 1, 0); step("R2");
    chk("R2", "handled set", 32'(outFlags), 32'h22);
    drive(1, 6'h00, 16'h0055, 1, 1, 0); step("R2");
    chk("R2", "stop over", 32'(fetchBlock), 0);
    // R3: pending marks the next instruction serialize-before
    drive(1, 6'h20, 16'h0066, 1, 1, 0); step("R3");
    chk("R3", "forced serBefore", 32'(outFlags), 32'h21);
    drive(1, 6'h00, 16'h0077, 1, 1, 0); step("R3");
    chk("R3", "pending cleared", 32'(outFlags), 32'h00);

    // R3 + R4: store-conditional then a temporary barrier
    drive(1, 6'h04, 16'h0088, 1, 1, 0); step("R2");
    drive(0, 6'h00, 16'h0000, 1, 1, 0); step("R3");
    drive(1, 6'h10, 16'h0099, 1, 1, 0); step("R3");
    chk("R4", "temp count", 32'(tempSerializingCount), 1);
    drive(0, 6'h00, 16'h0000, 1, 1, 0); step("R5");
    drive(0, 6'h00, 16'h0000, 1, 1, 0); step("R4");
    chk("R4", "temp replay unhandled", 32'(outFlags), 32'h10);

    // R8: squash while blocked
    drive(1, 6'h08, 16'h00AA, 0, 0, 0); step("R1");
    drive(1, 6'h08, 16'h00AB, 0, 0, 1); step("R8");
    chk("R8", "unblocked", 32'(fetchBlock), 0);
    drive(1, 6'h00, 16'h00BB, 0, 0, 0); step("R8");
    chk("R8", "runs after squash", 32'(outTag), 32'hBB);

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] f;
      f[0] = ($urandom_range(0, 99) < 8);
      f[1] = ($urandom_range(0, 99) < 8);
      f[2] = ($urandom_range(0, 99) < 5);
      f[3] = ($urandom_range(0, 99) < 5);
      f[4] = ($urandom_range(0, 99) < 30);
      f[5] = ($urandom_range(0, 99) < 20);
      drive($urandom_range(0, 99) < 70, f, TAG_W'($urandom()),
            $urandom_range(0, 99) < 40, $urandom_range(0, 99) < 40,
            $urandom_range(0, 99) < 2);
      step("R9");
    end

    summary();
    $finish;
  end

endmodule